// File: doc/BRIEF.md
# External Bus Word-Lane Steering Unit

This unit connects an internal requester to an external memory bus. The bus addresses 32-bit words and carries 64 data bits. Each word travels on one half of the data bus, and the half is chosen by the low bit of the word address. A request asks for one word, or for two words at consecutive addresses. It carries a start address, a direction flag and up to two words of write data. When a two-word request starts on an even address, both words fit in a single 64-bit bus cycle. When it starts on an odd address, the unit issues two single-word cycles back to back.

The unit also drives a page indication to an external DRAM controller. The indication is raised for every bus cycle whose address lies in a different DRAM page from the previous bus cycle. The page size comes from a 3-bit select field, normally driven from a control register. A flush input forgets the previous address, so the next access is always treated as a page change. Read data is returned to the requester one word per cycle, in address order. The requester uses a valid/ready handshake, and the bus side closes each cycle with an acknowledge.

Top module: `xbus_lane_steer`

## Requirements
- R1: `req_ready` is high only when no bus cycle is open and no second half of a split request is waiting. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Its first bus cycle starts on the next cycle.
- R2: A one-word request at an even address drives `bus_lane_en` = 2'b01 (bit 0 selects data bits 31:0). At an odd address it drives 2'b10 (bit 1 selects bits 63:32). On writes the word is placed on the selected lane and the other lane carries zero.
- R3: A two-word request at an even address A is issued as one bus cycle with address A and `bus_lane_en` = 2'b11. The first word is on bits 31:0 and the second on bits 63:32.
- R4: A two-word request at an odd address A is issued as two cycles. The first has address A and lanes 2'b10, carrying the first word. The second has address A+1 and lanes 2'b01, carrying the second word. The second cycle starts on the cycle right after the first is acknowledged.
- R5: On reads, `rsp_valid` pulses high for one cycle per word, and the words come in ascending address order. The first word appears the cycle after the acknowledge. The upper word of a merged read appears one cycle later.
- R6: `page_sel` value s selects a page size of 2^(8+s) words, from 256 words (s=0) to 32768 words (s=7).
- R7: `bus_page` is high for a whole bus cycle when the cycle's address differs from the previous bus cycle's address in any bit at or above position 8+s. Each half of a split request counts as its own cycle.
- R8: The first bus cycle after reset raises `bus_page`. So does the first bus cycle that starts on or after a cycle where `flush` is high.
- R9: While a cycle waits for `bus_ack`, the bus address, lanes, write data and page output do not change. `bus_rd` and `bus_wr` are never high together, and both are low when no cycle is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_pair | input | 1 | Request covers two consecutive words |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Word address of the first word |
| req_wdata0 | input | 32 | Write data for the first word |
| req_wdata1 | input | 32 | Write data for the second word |
| page_sel | input | 3 | Page size select (2^(8+s) words) |
| flush | input | 1 | Forget the previous page |
| bus_addr | output | 32 | Bus word address |
| bus_lane_en | output | 2 | Lane enables: bit 0 low lane, bit 1 high lane |
| bus_wdata | output | 64 | Bus write data |
| bus_rd | output | 1 | Read cycle open |
| bus_wr | output | 1 | Write cycle open |
| bus_page | output | 1 | DRAM page change for this cycle |
| bus_ack | input | 1 | Bus cycle completes on this edge |
| bus_rdata | input | 64 | Bus read data, valid with `bus_ack` |
| rsp_valid | output | 1 | Read word valid (one-cycle pulse) |
| rsp_data | output | 32 | Read word |

## Verification
The hardest case to reach is an odd-start two-word access whose two halves fall in different pages. The first half must not raise the page indication, and the second half must raise it, even though only one request was made. The stimulus first sets the smallest page size. It then makes a single access inside one page, so that the previous address sits in that page. After that it issues a split request that starts on the last word of the page. The page flag recorded for each half is then compared separately. A second hard case is a merged read: its two responses must come out on consecutive cycles, even though the bus gave them in a single acknowledge. A responder with zero latency checks that timing, and a responder with several wait cycles checks that the bus outputs hold steady.

// File: rtl/xls_pkg.sv
package xls_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_CYC  = 1'b1
  } xls_state_t;

  localparam logic [1:0] LANE_LO   = 2'b01;
  localparam logic [1:0] LANE_HI   = 2'b10;
  localparam logic [1:0] LANE_BOTH = 2'b11;
endpackage

// File: rtl/xls_cycle_plan.sv
module xls_cycle_plan #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input  logic                  pair,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     w0,
  input  logic [WORD_W-1:0]     w1,
  output logic [1:0]            first_lanes,
  output logic [2*WORD_W-1:0]   first_wdata,
  output logic                  split,
  output logic [ADDR_W-1:0]     second_addr,
  output logic [2*WORD_W-1:0]   second_wdata
);
  import xls_pkg::*;
  localparam int BUS_W = 2 * WORD_W;

  function automatic logic [1:0] lane_of(input logic odd);
    return odd ? LANE_HI : LANE_LO;
  endfunction

  function automatic logic [BUS_W-1:0] place_word(input logic odd,
                                                  input logic [WORD_W-1:0] w);
    return odd ? {w, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, w};
  endfunction

  logic odd_start;
  assign odd_start = addr[0];

  always_comb begin
    if (pair && !odd_start) begin
      first_lanes = LANE_BOTH;
      first_wdata = {w1, w0};
    end else begin
      first_lanes = lane_of(odd_start);
      first_wdata = place_word(odd_start, w0);
    end
  end

  assign split        = pair && odd_start;
  assign second_addr  = addr + ADDR_W'(1);
  assign second_wdata = place_word(1'b0, w1);
endmodule

// File: rtl/xls_page_track.sv
module xls_page_track #(
  parameter int ADDR_W    = 32,
  parameter int PSEL_W    = 3,
  parameter int BASE_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [PSEL_W-1:0] page_sel,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  output logic              crossing
);
  logic [ADDR_W-1:0] last_addr_q;
  logic              last_v_q;

  function automatic logic page_differs(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] b,
                                        input logic [PSEL_W-1:0] sel);
    int unsigned sh;
    sh = BASE_LOG2 + int'(sel);
    return ((a ^ b) >> sh) != '0;
  endfunction

  assign crossing = flush || !last_v_q || page_differs(load_addr, last_addr_q, page_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_v_q    <= 1'b0;
      last_addr_q <= '0;
    end else if (load) begin
      last_v_q    <= 1'b1;
      last_addr_q <= load_addr;
    end else if (flush) begin
      last_v_q    <= 1'b0;
    end
  end
endmodule

// File: rtl/xls_read_return.sv
module xls_read_return #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_done,
  input  logic [1:0]          lanes,
  input  logic [2*WORD_W-1:0] rdata,
  output logic                rsp_valid,
  output logic [WORD_W-1:0]   rsp_data
);
  import xls_pkg::*;
  logic              hold_v_q;
  logic [WORD_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      hold_v_q  <= 1'b0;
      hold_q    <= '0;
    end else if (rd_done) begin
      rsp_valid <= 1'b1;
      rsp_data  <= (lanes == LANE_HI) ? rdata[2*WORD_W-1:WORD_W] : rdata[WORD_W-1:0];
      hold_v_q  <= (lanes == LANE_BOTH);
      hold_q    <= rdata[2*WORD_W-1:WORD_W];
    end else if (hold_v_q) begin
      rsp_valid <= 1'b1;
      rsp_data  <= hold_q;
      hold_v_q  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xbus_lane_steer.sv
module xbus_lane_steer #(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int PSEL_W    = 3,
  parameter int BASE_LOG2 = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_pair,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [WORD_W-1:0]    req_wdata0,
  input  logic [WORD_W-1:0]    req_wdata1,
  input  logic [PSEL_W-1:0]    page_sel,
  input  logic                 flush,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [1:0]           bus_lane_en,
  output logic [2*WORD_W-1:0]  bus_wdata,
  output logic                 bus_rd,
  output logic                 bus_wr,
  output logic                 bus_page,
  input  logic                 bus_ack,
  input  logic [2*WORD_W-1:0]  bus_rdata,
  output logic                 rsp_valid,
  output logic [WORD_W-1:0]    rsp_data
);
  import xls_pkg::*;
  localparam int BUS_W = 2 * WORD_W;

  xls_state_t        state_q;
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [BUS_W-1:0]  pend_wdata_q;
  logic              write_q;

  logic [1:0]        plan_lanes;
  logic [BUS_W-1:0]  plan_wdata;
  logic              plan_split;
  logic [ADDR_W-1:0] plan_addr2;
  logic [BUS_W-1:0]  plan_wdata2;

  // Named events for the checker
  logic              acc_fire;
  logic              cyc_done;
  logic              seg_load;
  logic              seg_split_pending;
  logic [ADDR_W-1:0] seg_addr;
  logic              seg_cross;

  assign req_ready         = (state_q == ST_IDLE);
  assign acc_fire          = req_valid && req_ready;
  assign cyc_done          = (state_q == ST_CYC) && bus_ack;
  assign seg_split_pending = pend_q;
  assign seg_load          = acc_fire || (cyc_done && pend_q);
  assign seg_addr          = acc_fire ? req_addr : pend_addr_q;

  xls_cycle_plan #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_plan (
    .pair         (req_pair),
    .addr         (req_addr),
    .w0           (req_wdata0),
    .w1           (req_wdata1),
    .first_lanes  (plan_lanes),
    .first_wdata  (plan_wdata),
    .split        (plan_split),
    .second_addr  (plan_addr2),
    .second_wdata (plan_wdata2)
  );

  xls_page_track #(.ADDR_W(ADDR_W), .PSEL_W(PSEL_W), .BASE_LOG2(BASE_LOG2)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .page_sel  (page_sel),
    .load      (seg_load),
    .load_addr (seg_addr),
    .crossing  (seg_cross)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      pend_q       <= 1'b0;
      pend_addr_q  <= '0;
      pend_wdata_q <= '0;
      write_q      <= 1'b0;
      bus_addr     <= '0;
      bus_lane_en  <= '0;
      bus_wdata    <= '0;
      bus_rd       <= 1'b0;
      bus_wr       <= 1'b0;
      bus_page     <= 1'b0;
    end else if (acc_fire) begin
      state_q      <= ST_CYC;
      pend_q       <= plan_split;
      pend_addr_q  <= plan_addr2;
      pend_wdata_q <= plan_wdata2;
      write_q      <= req_write;
      bus_addr     <= req_addr;
      bus_lane_en  <= plan_lanes;
      bus_wdata    <= plan_wdata;
      bus_rd       <= !req_write;
      bus_wr       <= req_write;
      bus_page     <= seg_cross;
    end else if (cyc_done) begin
      if (pend_q) begin
        pend_q      <= 1'b0;
        bus_addr    <= pend_addr_q;
        bus_lane_en <= LANE_LO;
        bus_wdata   <= write_q ? pend_wdata_q : '0;
        bus_page    <= seg_cross;
      end else begin
        state_q <= ST_IDLE;
        bus_rd  <= 1'b0;
        bus_wr  <= 1'b0;
      end
    end
  end

  xls_read_return #(.WORD_W(WORD_W)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_done   (cyc_done && bus_rd),
    .lanes     (bus_lane_en),
    .rdata     (bus_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/xls_checker.sv
module xls_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] bus_addr,
  input logic [1:0]  bus_lane_en,
  input logic [63:0] bus_wdata,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic        bus_page,
  input logic        bus_ack,
  input logic        rsp_valid,
  input logic        cyc_done,
  input logic        seg_split_pending
);
  logic open_cyc;
  assign open_cyc = bus_rd || bus_wr;

  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    open_cyc |-> !req_ready);

  a_r1_accept_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> open_cyc);

  a_r2_lane_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (open_cyc && bus_lane_en != 2'b11) |-> (bus_lane_en == (bus_addr[0] ? 2'b10 : 2'b01)));

  a_r3_pair_even: assert property (@(posedge clk) disable iff (!rst_n)
    (open_cyc && bus_lane_en == 2'b11) |-> !bus_addr[0]);

  a_r4_split_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && seg_split_pending) |=> (open_cyc && !bus_addr[0] && bus_lane_en == 2'b01));

  a_r5_rsp_source: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(bus_rd && bus_ack) || $past(rsp_valid)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (open_cyc && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_lane_en)
                               && $stable(bus_wdata) && $stable(bus_page)));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
endmodule

bind xbus_lane_steer xls_checker u_chk (.*);

// File: tb/xbus_lane_steer_tb.sv
module xbus_lane_steer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_pair = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata0 = '0;
  logic [31:0] req_wdata1 = '0;
  logic [2:0]  page_sel = '0;
  logic        flush = 1'b0;
  logic [31:0] bus_addr;
  logic [1:0]  bus_lane_en;
  logic [63:0] bus_wdata;
  logic        bus_rd;
  logic        bus_wr;
  logic        bus_page;
  logic        bus_ack = 1'b0;
  logic [63:0] bus_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  xbus_lane_steer u_dut (.*);

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int ack_lat = 0;
  int wait_cnt = 0;

  // bus cycle log, taken when acknowledge is raised
  int          log_n = 0;
  logic [31:0] lg_addr [64];
  logic [1:0]  lg_lanes[64];
  logic [63:0] lg_wdata[64];
  logic        lg_page [64];
  logic        lg_rd   [64];
  int          lg_cyc  [64];
  logic        lg_cont [64];
  int          rsp_n = 0;
  logic [31:0] rs_data [64];
  int          rs_cyc  [64];

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rsp_valid && rsp_n < 64) begin
      rs_data[rsp_n] = rsp_data;
      rs_cyc[rsp_n]  = cyc;
      rsp_n++;
    end
    if (bus_ack) begin
      bus_ack = 1'b0;
      wait_cnt = 0;
      if (log_n > 0) lg_cont[log_n-1] = bus_rd || bus_wr;
    end else if ((bus_rd || bus_wr) && log_n < 64) begin
      if (wait_cnt >= ack_lat) begin
        bus_ack = 1'b1;
        bus_rdata = {mem_word(bus_addr | 32'd1), mem_word(bus_addr & ~32'd1)};
        lg_addr[log_n]  = bus_addr;
        lg_lanes[log_n] = bus_lane_en;
        lg_wdata[log_n] = bus_wdata;
        lg_page[log_n]  = bus_page;
        lg_rd[log_n]    = bus_rd;
        lg_cyc[log_n]   = cyc;
        lg_cont[log_n]  = 1'b0;
        log_n++;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic pair, input logic wr, input logic [31:0] a,
                       input logic [31:0] w0, input logic [31:0] w1, input int ncyc);
    int tgt;
    tgt = log_n + ncyc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_pair = pair; req_write = wr;
    req_addr = a; req_wdata0 = w0; req_wdata1 = w1;
    @(negedge clk);
    req_valid = 1'b0;
    while (log_n < tgt) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", 64'(req_ready), 1);
    chk((bus_rd | bus_wr) === 1'b0, "R9 no strobe after reset", 64'(bus_rd | bus_wr), 0);
    chk(rsp_valid === 1'b0, "R5 no response after reset", 64'(rsp_valid), 0);
  endtask

  task automatic t_single;
    int b;
    b = log_n;
    issue(0, 1, 32'h0000_0010, 32'hDEAD_BEEF, 32'h0, 1);
    chk(lg_lanes[b] == 2'b01, "R2 even lanes", 64'(lg_lanes[b]), 1);
    chk(lg_wdata[b] == {32'h0, 32'hDEAD_BEEF}, "R2 even data", lg_wdata[b], {32'h0, 32'hDEAD_BEEF});
    chk(lg_page[b] == 1'b1, "R8 first after reset", 64'(lg_page[b]), 1);
    b = log_n;
    issue(0, 1, 32'h0000_0021, 32'h1234_5678, 32'h0, 1);
    chk(lg_lanes[b] == 2'b10, "R2 odd lanes", 64'(lg_lanes[b]), 2);
    chk(lg_wdata[b] == {32'h1234_5678, 32'h0}, "R2 odd data", lg_wdata[b], {32'h1234_5678, 32'h0});
    chk(lg_page[b] == 1'b0, "R7 same page", 64'(lg_page[b]), 0);
    b = log_n;
    issue(0, 0, 32'h0000_0033, 32'h0, 32'h0, 1);
    chk(rsp_n > 0 && rs_data[rsp_n-1] == mem_word(32'h33), "R5 odd read word",
        rs_data[rsp_n-1], mem_word(32'h33));
    chk(rs_cyc[rsp_n-1] == lg_cyc[b] + 1, "R5 read timing", 64'(rs_cyc[rsp_n-1]), 64'(lg_cyc[b] + 1));
  endtask

  task automatic t_pair_even;
    int b, r;
    b = log_n;
    issue(1, 1, 32'h0000_0040, 32'hAAAA_0001, 32'hBBBB_0002, 1);
    chk(log_n == b + 1 && lg_lanes[b] == 2'b11, "R3 merged lanes", 64'(lg_lanes[b]), 3);
    chk(lg_wdata[b] == {32'hBBBB_0002, 32'hAAAA_0001}, "R3 merged data", lg_wdata[b],
        {32'hBBBB_0002, 32'hAAAA_0001});
    b = log_n; r = rsp_n;
    issue(1, 0, 32'h0000_0050, 32'h0, 32'h0, 1);
    chk(rsp_n == r + 2, "R5 two responses", 64'(rsp_n - r), 2);
    chk(rs_data[r] == mem_word(32'h50) && rs_data[r+1] == mem_word(32'h51), "R5 address order",
        {rs_data[r], rs_data[r+1]}, {mem_word(32'h50), mem_word(32'h51)});
    chk(rs_cyc[r] == lg_cyc[b] + 1 && rs_cyc[r+1] == lg_cyc[b] + 2, "R5 pulse cycles",
        64'(rs_cyc[r+1]), 64'(lg_cyc[b] + 2));
  endtask

  task automatic t_split_page;
    int b, r;
    page_sel = 3'd0;
    issue(0, 1, 32'h0000_0210, 32'h1, 32'h0, 1);
    b = log_n;
    issue(1, 1, 32'h0000_02FF, 32'hCAFE_0001, 32'hCAFE_0002, 2);
    chk(lg_addr[b] == 32'h2FF && lg_lanes[b] == 2'b10, "R4 split first", 64'(lg_lanes[b]), 2);
    chk(lg_wdata[b] == {32'hCAFE_0001, 32'h0}, "R4 split first data", lg_wdata[b], {32'hCAFE_0001, 32'h0});
    chk(lg_addr[b+1] == 32'h300 && lg_lanes[b+1] == 2'b01, "R4 split second", 64'(lg_addr[b+1]), 32'h300);
    chk(lg_wdata[b+1] == {32'h0, 32'hCAFE_0002}, "R4 split second data", lg_wdata[b+1],
        {32'h0, 32'hCAFE_0002});
    chk(lg_cont[b] == 1'b1, "R4 back to back", 64'(lg_cont[b]), 1);
    chk(lg_page[b] == 1'b0, "R7 split half one same page", 64'(lg_page[b]), 0);
    chk(lg_page[b+1] == 1'b1, "R7 split half two new page", 64'(lg_page[b+1]), 1);
    b = log_n; r = rsp_n;
    issue(1, 0, 32'h0000_0305, 32'h0, 32'h0, 2);
    chk(rsp_n == r + 2 && rs_data[r] == mem_word(32'h305) && rs_data[r+1] == mem_word(32'h306),
        "R5 split read order", {rs_data[r], rs_data[r+1]}, {mem_word(32'h305), mem_word(32'h306)});
  endtask

  task automatic t_page_size;
    int b;
    page_sel = 3'd7;
    b = log_n;
    issue(0, 1, 32'h0000_7FFF, 32'h5, 32'h0, 1);
    chk(lg_page[b] == 1'b0, "R6 32768-word page same", 64'(lg_page[b]), 0);
    b = log_n;
    issue(0, 1, 32'h0000_8000, 32'h6, 32'h0, 1);
    chk(lg_page[b] == 1'b1, "R6 32768-word page boundary", 64'(lg_page[b]), 1);
    page_sel = 3'd1;
    b = log_n;
    issue(0, 1, 32'h0000_81FF, 32'h7, 32'h0, 1);
    chk(lg_page[b] == 1'b0, "R6 512-word page same", 64'(lg_page[b]), 0);
    b = log_n;
    issue(0, 1, 32'h0000_8200, 32'h8, 32'h0, 1);
    chk(lg_page[b] == 1'b1, "R6 512-word page boundary", 64'(lg_page[b]), 1);
  endtask

  task automatic t_flush_stall;
    int b;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    ack_lat = 3;
    b = log_n;
    issue(0, 1, 32'h0000_8201, 32'h9, 32'h0, 1);
    chk(lg_page[b] == 1'b1, "R8 page after flush", 64'(lg_page[b]), 1);
    chk(lg_addr[b] == 32'h8201 && lg_wdata[b] == {32'h9, 32'h0}, "R9 held through wait",
        lg_wdata[b], {32'h9, 32'h0});
    b = log_n;
    issue(0, 1, 32'h0000_8202, 32'hA, 32'h0, 1);
    chk(lg_page[b] == 1'b0, "R7 no page after refill", 64'(lg_page[b]), 0);
    chk((bus_rd | bus_wr) == 1'b0 && req_ready == 1'b1, "R9 idle after cycle",
        64'(bus_rd | bus_wr), 0);
    ack_lat = 0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_pair_even();
    t_split_page();
    t_page_size();
    t_flush_stall();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule